// File: doc/BRIEF.md
# Edge-Detect GPIO Interrupt Controller

This block watches a set of already-synchronized general-purpose input pins and turns selected transitions into interrupt requests. Each pin carries a two-bit edge selection that arms detection of falling edges, rising edges, or both. A detected edge sets that pin's status bit. A per-pin mask bit decides whether that status may reach the host. All unmasked pending bits are ORed into a single registered, level-sensitive interrupt line.

Software reaches every register through a simple byte-wide bus with a one-cycle registered read. Edge selections are packed four pins to a byte. Status and mask are packed eight pins to a byte. A small control byte selects two behaviours. The first is whether masked pins may still latch status. The second is whether reading a status byte clears the bits it returned, in place of clearing by writing ones. A typical service routine does four things: it reads status, masks the pin and clears its bit, runs the handler, and then unmasks the pin.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, and all status, edge-selection and control bits are 0. The interrupt output is 0.
- R2: Edge-selection byte b sits at address b, for b = 0 to 4. In that byte, bit 2*s arms falling-edge detection for pin 4*b+s, and bit 2*s+1 arms rising-edge detection for the same pin.
- R3: A pin whose selection arms a given edge latches its status bit when that edge is seen. A pin with neither bit set never latches.
- R4: The interrupt output is 1 exactly when some pin has status 1 and mask 0. It follows the status and mask registers one clock later.
- R5: Status byte k is at address 8+k and mask byte k is at address 12+k. Each byte covers pins 8*k to 8*k+7. Writing to a status byte clears every status bit written as 1 and leaves every bit written as 0 unchanged. A mask bit of 1 blocks its pin.
- R6: Control address 16 holds three bits: bit 0 is exclusive enable, bit 1 is pending-disable and bit 2 is clear-on-read. With bit 2 set, reading a status byte returns its bits and then clears them. With bit 2 clear, reads do not disturb status.
- R7: An edge that arrives in the same cycle as a clear of its status bit leaves that bit set.
- R8: With pending-disable set, masked pins do not latch new status. With it clear, masked pins still latch, and the pending bit raises the interrupt once the pin is unmasked.
- R9: Detection compares each input with its value one cycle earlier. Changing an edge selection does not create an event, even while the pin is high. A selection written in the same cycle as an edge applies only to later edges.
- R10: Bits beyond pin 17 do not exist. They read as 0, and writes to them have no effect. This covers the top half of edge byte 4, bits 7:2 of status byte 2 and bits 7:2 of mask byte 2.
- R11: A read returns its data on the bus in the cycle after the read strobe. Addresses that hold no register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 18 | Synchronized GPIO input levels |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with its default parameters. These give 18 pins, five edge bytes and three status and mask bytes, with the register bases at 0, 8, 12 and 16. Because the last edge byte and the last status and mask bytes are only partly populated, the nonexistent bits of R10 can be reached and checked. Eighteen pins also leave room to place rising, falling and dual-edge pins in different bytes at the same time.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CTRL_BITS = 3;

  typedef struct packed {
    logic clr_on_rd;
    logic pend_dis;
    logic excl_en;
  } ctrl_t;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int NPINS = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [2*NPINS-1:0] cfg_we,
  input  logic [2*NPINS-1:0] cfg_wd,
  output logic [2*NPINS-1:0] cfg,
  output logic [NPINS-1:0]   ev
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      logic prev_q;
      logic [1:0] sel_q;   // [0] falling, [1] rising

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          sel_q  <= 2'b00;
        end else begin
          prev_q <= pin_in[p];
          if (cfg_we[2*p])   sel_q[0] <= cfg_wd[2*p];
          if (cfg_we[2*p+1]) sel_q[1] <= cfg_wd[2*p+1];
        end
      end

      assign ev[p] = armed_q &
                     ((sel_q[0] &  prev_q & ~pin_in[p]) |
                      (sel_q[1] & ~prev_q &  pin_in[p]));
      assign cfg[2*p]   = sel_q[0];
      assign cfg[2*p+1] = sel_q[1];

      // R9
      edge_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
        ev[p] |-> (pin_in[p] != $past(pin_in[p])));
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] ev,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] mask_we,
  input  logic [NPINS-1:0] mask_wd,
  input  logic             pend_dis,
  output logic [NPINS-1:0] status,
  output logic [NPINS-1:0] mask,
  output logic             irq
);
  logic [NPINS-1:0] latch_en;
  logic [NPINS-1:0] setv;

  assign latch_en = ~({NPINS{pend_dis}} & mask);
  assign setv     = ev & latch_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | setv;
      mask   <= (mask & ~mask_we) | (mask_wd & mask_we);
      irq    <= |(status & ~mask);
    end
  end

  // R3 and R7: a qualified edge is latched even against a clear
  edge_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (setv != '0) |=> ((status & $past(setv)) == $past(setv)));

  // R5: no status bit rises without an edge
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(ev)) == '0));

  // R8
  pend_dis_block_chk: assert property (@(posedge clk) disable iff (rst)
    pend_dis |=> ((status & ~$past(status) & $past(mask)) == '0));

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(status & ~mask) != '0));
endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS     = 18,
  parameter int ADDR_W    = 5,
  parameter int EDGE_BASE = 0,
  parameter int STAT_BASE = 8,
  parameter int MASK_BASE = 12,
  parameter int CTRL_ADDR = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq
);
  localparam int EDGE_BANKS = (2*NPINS + 7) / 8;
  localparam int BYTE_BANKS = (NPINS + 7) / 8;
  localparam int TOP_USED   = NPINS - 8*(BYTE_BANKS-1);
  localparam logic [7:0] TOP_PAD = 8'(16'h00FF << TOP_USED);

  ctrl_t            ctrl_q;
  logic [2*NPINS-1:0] cfg, cfg_we, cfg_wd;
  logic [NPINS-1:0] ev, clr, mask_we, mask_wd, status, mask;
  logic [7:0]       rd_mux;

  always_comb begin
    clr = '0; mask_we = '0; mask_wd = '0;
    cfg_we = '0; cfg_wd = '0;
    rd_mux = 8'h00;
    for (int b = 0; b < BYTE_BANKS; b++) begin
      for (int i = 0; i < 8; i++) begin
        if (8*b + i < NPINS) begin
          if (bus_addr == ADDR_W'(STAT_BASE + b)) begin
            if (bus_wr && bus_wdata[i]) clr[8*b+i] = 1'b1;
            if (bus_rd && ctrl_q.clr_on_rd) clr[8*b+i] = 1'b1;
            rd_mux[i] = status[8*b+i];
          end
          if (bus_addr == ADDR_W'(MASK_BASE + b)) begin
            mask_we[8*b+i] = bus_wr;
            mask_wd[8*b+i] = bus_wdata[i];
            rd_mux[i] = mask[8*b+i];
          end
        end
      end
    end
    for (int b = 0; b < EDGE_BANKS; b++) begin
      for (int i = 0; i < 8; i++) begin
        if (8*b + i < 2*NPINS) begin
          if (bus_addr == ADDR_W'(EDGE_BASE + b)) begin
            cfg_we[8*b+i] = bus_wr;
            cfg_wd[8*b+i] = bus_wdata[i];
            rd_mux[i] = cfg[8*b+i];
          end
        end
      end
    end
    if (bus_addr == ADDR_W'(CTRL_ADDR)) rd_mux = {{(8-CTRL_BITS){1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  gpio_edge_detect #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .cfg_we(cfg_we), .cfg_wd(cfg_wd), .cfg(cfg), .ev(ev)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_stat (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr),
    .mask_we(mask_we), .mask_wd(mask_wd), .pend_dis(ctrl_q.pend_dis),
    .status(status), .mask(mask), .irq(irq)
  );

  // R10
  top_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(STAT_BASE + BYTE_BANKS - 1) ||
                bus_addr == ADDR_W'(MASK_BASE + BYTE_BANKS - 1)))
    |=> ((bus_rdata & TOP_PAD) == 8'h00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_gpio_edge_irq_ctrl.sv
module tb_gpio_edge_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] pins = '0;
  logic [4:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_irq_ctrl dut (
    .clk(clk), .rst(rst), .pin_in(pins), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    brd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic setpins(input logic [17:0] v);
    @(negedge clk); pins = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    rchk("R1 mask0", 12, 8'hFF);
    rchk("R1 mask1", 13, 8'hFF);
    rchk("R1/R10 mask2", 14, 8'h03);
    for (int k = 0; k < 3; k++) rchk("R1 status", 5'(8 + k), 8'h00);
    for (int k = 0; k < 5; k++) rchk("R1 edge", 5'(k), 8'h00);
    rchk("R1 ctrl", 16, 8'h00);
  endtask

  task automatic t_edges;
    bwr(1, 8'h08);  // pin5 rising
    bwr(2, 8'h04);  // pin9 falling
    bwr(4, 8'h0C);  // pin17 both
    rchk("R2 edge1 readback", 1, 8'h08);
    setpins(18'h00201);  // pin0 and pin9 rise: not armed
    rchk("R3 none bank0", 8, 8'h00);
    rchk("R3 rise unarmed bank1", 9, 8'h00);
    setpins(18'h20221);  // pin5, pin17 rise
    rchk("R3 rise pin5", 8, 8'h20);
    rchk("R6 no clear on read", 8, 8'h20);
    rchk("R3 both pin17 rise", 10, 8'h02);
    bwr(8, 8'hFF); bwr(10, 8'hFF);
    rchk("R5 w1c bank0", 8, 8'h00);
    setpins(18'h00001);  // pin5, pin9, pin17 fall
    rchk("R3 fall unarmed pin5", 8, 8'h00);
    rchk("R3 fall pin9", 9, 8'h02);
    rchk("R3 both pin17 fall", 10, 8'h02);
    bwr(9, 8'hFF); bwr(10, 8'hFF);
  endtask

  task automatic t_irq;
    bwr(12, 8'hDF);
    chk("R4 unmasked no status", irq, 0);
    @(negedge clk); pins[5] = 1'b1;
    @(negedge clk); chk("R4 irq one cycle after status", irq, 0);
    @(negedge clk); chk("R4 irq raised", irq, 1);
    bwr(8, 8'h00);
    rchk("R5 zero write keeps", 8, 8'h20);
    bwr(8, 8'h20);
    chk("R4 irq lags clear", irq, 1);
    @(negedge clk); chk("R5 irq after w1c", irq, 0);
    setpins(18'h00001); setpins(18'h00021);
    @(negedge clk); chk("R4 irq again", irq, 1);
    bwr(12, 8'hFF);
    @(negedge clk); chk("R4 mask gates irq", irq, 0);
    bwr(8, 8'h20);
  endtask

  task automatic t_cor;
    bwr(16, 8'h04);
    setpins(18'h00001); setpins(18'h00021);
    rchk("R6 cor returns", 8, 8'h20);
    rchk("R6 cor cleared", 8, 8'h00);
    bwr(16, 8'h00);
  endtask

  task automatic t_collide;
    setpins(18'h00001);
    setpins(18'h00021);
    setpins(18'h00001);
    @(negedge clk); pins[5] = 1'b1; addr = 8; wdata = 8'h20; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rchk("R7 edge beats clear", 8, 8'h20);
    bwr(8, 8'h20);
  endtask

  task automatic t_pend;
    bwr(16, 8'h02);
    setpins(18'h00221); setpins(18'h00021);
    rchk("R8 pend_dis blocks", 9, 8'h00);
    bwr(16, 8'h00);
    setpins(18'h00221); setpins(18'h00021);
    rchk("R8 masked latch", 9, 8'h02);
    chk("R8 masked no irq", irq, 0);
    bwr(13, 8'hFD);
    chk("R8 irq lag", irq, 0);
    @(negedge clk); chk("R8 irq on unmask", irq, 1);
    bwr(9, 8'h02); bwr(13, 8'hFF);
  endtask

  task automatic t_cfg;
    setpins(18'h00025);  // pin2 high, unarmed
    bwr(0, 8'h20);       // arm pin2 rising while high
    @(negedge clk);
    rchk("R9 no spurious on cfg", 8, 8'h00);
    @(negedge clk); pins[3] = 1'b1; addr = 0; wdata = 8'hA0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rchk("R9 same-cycle cfg not applied", 8, 8'h00);
    setpins(18'h00025); setpins(18'h0002D);
    rchk("R9 cfg applied later", 8, 8'h08);
    bwr(8, 8'hFF);
  endtask

  task automatic t_unused;
    bwr(14, 8'hFF);
    rchk("R10 mask2 pad", 14, 8'h03);
    bwr(10, 8'hFF);
    rchk("R10 status2 pad", 10, 8'h00);
    bwr(4, 8'hFF);
    rchk("R10 edge4 pad", 4, 8'h0F);
    bwr(4, 8'h0C);
    rchk("R10 mask0 untouched", 12, 8'hFF);
    bwr(16, 8'hFF);
    rchk("R6/R11 ctrl readback", 16, 8'h07);
    bwr(16, 8'h00);
    rchk("R11 unmapped 20", 20, 8'h00);
    rchk("R11 unmapped 5", 5, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_edges;
    t_irq;
    t_cor;
    t_collide;
    t_pend;
    t_cfg;
    t_unused;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule